// File: doc/BRIEF.md
# Walsh Challenge Sequencer

This block feeds a delay-based entropy source with a fixed series of balanced challenge words and gathers the answers into a single response word. A start pulse begins a run. The block then issues 63 evaluations, one at a time. Each one presents a 64-bit challenge, raises a request, and waits for the source to signal completion with a sampled response bit.

The challenges are rows of a Walsh matrix, computed on the fly from a 6-bit row index. The index starts at 1 and counts up to 63. The all-ones row (index 0) is never issued, so every challenge holds as many ones as zeros. No challenge enters from outside, so the block and its source together form a fixed 63-bit weak fingerprint. When the last bit has been stored, a one-cycle valid pulse marks the assembled word.

Top module: `walsh_chal_seq`

## Requirements
- R1: After reset, eval_req_o, resp_valid_o, chal_o and resp_o are all zero, and they stay that way until a start pulse arrives.
- R2: A run issues the row indices 1, 2, …, 63 in ascending order, with exactly one evaluation per index. Bit j of the challenge for index i is the parity of the bitwise AND of i and j.
- R3: Every issued challenge has exactly 32 ones, and any two successive challenges differ in exactly 32 bit positions.
- R4: eval_req_o stays high, with chal_o unchanged, until eval_done_i is sampled high. It then drops for at least one cycle before the next evaluation.
- R5: The response bit sampled with eval_done_i during the evaluation of index i is stored at bit i-1 of resp_o.
- R6: resp_valid_o is high for exactly one cycle, the cycle after the 63rd bit is stored. resp_o holds its value after that pulse until the next accepted start.
- R7: A start pulse that arrives while a run is in progress is ignored. The index order and the bits already collected are unaffected.
- R8: A start pulse while idle clears resp_o and begins a new run at index 1.
- R9: While idle, chal_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begins a run when idle |
| chal_o | output | 64 | Challenge word presented to the source |
| eval_req_o | output | 1 | Evaluation request toward the source |
| eval_done_i | input | 1 | Source signals that the current evaluation is complete |
| resp_bit_i | input | 1 | Response bit, sampled together with eval_done_i |
| resp_o | output | 63 | Assembled response word |
| resp_valid_o | output | 1 | One-cycle marker that resp_o is complete |

## Verification
The bench builds the block with its default 6-bit index, so the full 64-bit, 63-word sequence runs end to end several times. A random parity-mask responder with random completion latency (zero cycles up to several cycles) exercises both back-to-back completion and long waits. Directed runs cover a single-bit mask, so the expected word follows from the index popcount, and an all-zero mask. One run repeats start pulses in mid-sequence to show they have no effect.

// File: rtl/walsh_chal_seq.sv
module walsh_chal_seq #(
  parameter int IDX_W = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_i,
  output logic [(1<<IDX_W)-1:0]     chal_o,
  output logic                      eval_req_o,
  input  logic                      eval_done_i,
  input  logic                      resp_bit_i,
  output logic [(1<<IDX_W)-2:0]     resp_o,
  output logic                      resp_valid_o
);
  localparam int CW = 1 << IDX_W;
  localparam int NB = CW - 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NB);

  logic [IDX_W-1:0] idx;
  logic             run;
  logic             req;
  logic             valid;
  logic [NB-1:0]    resp;
  logic [CW-1:0]    row;

  for (genvar j = 0; j < CW; j++) begin : g_row
    localparam logic [IDX_W-1:0] JV = IDX_W'(j);
    assign row[j] = ^(idx & JV);
  end

  assign chal_o       = run ? row : '0;
  assign eval_req_o   = req;
  assign resp_o       = resp;
  assign resp_valid_o = valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx   <= '0;
      run   <= 1'b0;
      req   <= 1'b0;
      valid <= 1'b0;
      resp  <= '0;
    end else begin
      valid <= 1'b0;
      if (!run) begin
        if (start_i) begin
          run  <= 1'b1;
          idx  <= IDX_W'(1);
          req  <= 1'b1;
          resp <= '0;
        end
      end else if (req) begin
        if (eval_done_i) begin
          resp[idx - IDX_W'(1)] <= resp_bit_i;
          req <= 1'b0;
          if (idx == LAST) begin
            run   <= 1'b0;
            valid <= 1'b1;
            idx   <= '0;
          end else begin
            idx <= idx + IDX_W'(1);
          end
        end
      end else begin
        req <= 1'b1;
      end
    end
  end

  AST_BALANCED: assert property (@(posedge clk) disable iff (!rst_n)
    eval_req_o |-> $countones(chal_o) == CW/2); // R3
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    eval_req_o && !eval_done_i |=> eval_req_o && $stable(chal_o)); // R4
  AST_REQ_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    eval_req_o && eval_done_i |=> !eval_req_o); // R4
  AST_VALID_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid_o |=> !resp_valid_o); // R6
  AST_RESP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    run && !(eval_req_o && eval_done_i) |=> $stable(resp_o)); // R7
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid_o |-> !eval_req_o && chal_o == '0); // R9
endmodule

// File: tb/sim_walsh_chal_seq.sv
`timescale 1ns/1ps
module sim_walsh_chal_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [63:0] chal_o;
  logic        eval_req_o;
  logic        eval_done_i = 1'b0;
  logic        resp_bit_i = 1'b0;
  logic [62:0] resp_o;
  logic        resp_valid_o;

  int total = 0;
  int bad = 0;
  int ev_idx = 1;
  int max_lat = 3;
  int runs_done = 0;
  logic [63:0] key = '0;
  logic [63:0] prev_chal = '0;
  logic [62:0] exp_resp = '0;

  always #2 clk = ~clk;

  walsh_chal_seq u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .chal_o(chal_o),
    .eval_req_o(eval_req_o), .eval_done_i(eval_done_i), .resp_bit_i(resp_bit_i),
    .resp_o(resp_o), .resp_valid_o(resp_valid_o)
  );

  function automatic logic [63:0] walsh(input int i);
    logic [63:0] w;
    for (int j = 0; j < 64; j++) w[j] = ^(6'(i) & 6'(j));
    return w;
  endfunction

  function automatic logic [62:0] expect_word(input logic [63:0] k);
    logic [62:0] r;
    for (int i = 1; i < 64; i++) r[i-1] = ^(walsh(i) & k);
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // responder modelling the entropy source
  initial begin
    bit pending = 0;
    int lat = 0;
    forever begin
      @(negedge clk);
      if (eval_done_i) begin
        eval_done_i = 1'b0;
        check(!eval_req_o, "R4 gap", 64'(eval_req_o), 64'd0);
      end else if (eval_req_o) begin
        if (!pending) begin
          pending = 1;
          lat = $urandom_range(0, max_lat);
          check(chal_o == walsh(ev_idx), "R2 codeword", chal_o, walsh(ev_idx));
          check($countones(chal_o) == 32, "R3 balance", 64'($countones(chal_o)), 64'd32);
          if (ev_idx > 1)
            check($countones(chal_o ^ prev_chal) == 32, "R3 distance",
                  64'($countones(chal_o ^ prev_chal)), 64'd32);
          prev_chal = chal_o;
        end else begin
          check(chal_o == prev_chal, "R4 stable", chal_o, prev_chal);
        end
        if (lat == 0) begin
          eval_done_i = 1'b1;
          resp_bit_i  = ^(chal_o & key);
          pending = 0;
          ev_idx++;
        end else lat--;
      end
    end
  end

  // valid monitor
  initial begin
    logic [62:0] held;
    forever begin
      @(negedge clk);
      if (resp_valid_o) begin
        check(resp_o == exp_resp, "R5 word", 64'(resp_o), 64'(exp_resp));
        check(ev_idx == 64, "R2 count", 64'(ev_idx), 64'd64);
        held = resp_o;
        @(negedge clk);
        check(!resp_valid_o, "R6 pulse", 64'(resp_valid_o), 64'd0);
        check(resp_o == held, "R6 hold", 64'(resp_o), 64'(held));
        runs_done++;
      end
    end
  end

  task automatic run_seq(input logic [63:0] k, input int lat, input bit mid_start);
    int target;
    target = runs_done + 1;
    key = k;
    max_lat = lat;
    exp_resp = expect_word(k);
    ev_idx = 1;
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(resp_o == '0, "R8 clear", 64'(resp_o), 64'd0);
    if (mid_start) begin
      repeat (40) @(negedge clk);
      start_i = 1'b1;
      repeat (3) @(negedge clk);
      start_i = 1'b0;
      repeat (30) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (runs_done < target) @(negedge clk);
    repeat (3) @(negedge clk);
    check(chal_o == '0, "R9 idle", chal_o, 64'd0);
    check(!eval_req_o, "R1 idle req", 64'(eval_req_o), 64'd0);
    check(resp_o == exp_resp, "R6 hold after", 64'(resp_o), 64'(exp_resp));
  endtask

  initial begin
    bit timeout = 0;
    void'($urandom(32'd1234));
    fork
      begin
        repeat (3) @(negedge clk);
        check(!eval_req_o, "R1 req", 64'(eval_req_o), 64'd0);
        check(!resp_valid_o, "R1 valid", 64'(resp_valid_o), 64'd0);
        check(chal_o == '0, "R1 chal", chal_o, 64'd0);
        check(resp_o == '0, "R1 resp", 64'(resp_o), 64'd0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(!eval_req_o && resp_o == '0, "R1 quiet", 64'(eval_req_o), 64'd0);
        run_seq({$urandom, $urandom}, 3, 0);
        run_seq(64'h8000_0000_0000_0000, 0, 0);
        run_seq({$urandom, $urandom}, 6, 1);
        run_seq(64'd0, 1, 0);
        run_seq({$urandom, $urandom}, 0, 1);
      end
      begin
        repeat (200000) @(posedge clk);
        timeout = 1;
      end
    join_any
    if (timeout) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=expired expected=finished");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule